// File: doc/BRIEF.md
# Transmit Packet Buffer Unpacker

This block takes one outgoing frame held in a 16-bit word-organised packet memory and streams it to a MAC transmitter one byte at a time. A stored packet starts at a word address given with `start`. It holds a status word at word 0 and a byte-count word at word 1. The frame data runs from word 2 onward. A final word closes the packet, and the high byte of that final word is the control byte. Each data word is sent low byte first. The destination and source addresses, the length/type field and the payload all pass through unchanged. Nothing is inserted and nothing is interpreted.

The block first reads the byte count and then the closing word. From these two words it works out how many data bytes the frame has, and only then does it stream. The stored count covers the whole packet: status word, count word, data and closing word. Its lowest bit is always treated as zero. The control byte's odd flag says whether the low byte of the closing word is the final data byte. The control byte's CRC flag asks for a CRC on this one frame. That request matters only when the global no-CRC setting is on; otherwise a CRC is always requested. A byte count outside the legal range makes the block drop the packet and raise an error strobe instead.

The memory port has a read latency of one cycle. The byte output is a valid/ready stream with a last flag.

Top module: `txu_top`

## Requirements
- R1: After reset, `txValid`, `memRdEn`, `busy`, `done` and `lenErr` are all low.
- R2: The effective byte count is the stored count word with bit 0 forced to 0. A stored count of 2k+1 behaves exactly like a stored count of 2k.
- R3: Data byte k (counting from 0) is taken from packet word 2 + k/2. It is the low byte when k is even and the high byte when k is odd. Bytes go out in increasing k, and no byte is altered or added.
- R4: The closing word sits at packet word (effective count / 2) − 1. Its bit 13 (bit 5 of the control byte) is the odd flag. The number of data bytes sent is the effective count − 6, plus 1 when the odd flag is set. The closing word's low byte is sent only when the odd flag is set.
- R5: `txLast` is high on the final data byte of a frame and on no other byte.
- R6: An effective count above 1536 or below 6 drops the packet. `lenErr` and `done` pulse together, and no byte is presented.
- R7: For a legal packet, `crcAppend` shows `!noCrcCfg | crcFlag` from the end of the control read until the next `start`. The CRC flag `crcFlag` is bit 12 of the closing word (bit 4 of the control byte).
- R8: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txLast` hold their values.
- R9: A legal packet with zero data bytes (effective count 6, odd flag clear) ends with a `done` pulse and never raises `txValid`.
- R10: `done` is a single-cycle pulse at the end of each packet. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin unpacking the packet at `baseAddr` (taken only when idle) |
| baseAddr | input | ADDR_W | Word address of the packet's status word |
| noCrcCfg | input | 1 | Global setting: automatic CRC disabled, so the per-frame CRC flag applies |
| memRdEn | output | 1 | Packet memory read strobe |
| memAddr | output | ADDR_W | Packet memory word address |
| memRdData | input | 16 | Read data, valid the cycle after `memRdEn` |
| txValid | output | 1 | A data byte is presented |
| txReady | input | 1 | MAC accepts the presented byte |
| txData | output | 8 | Data byte |
| txLast | output | 1 | Presented byte is the frame's final byte |
| crcAppend | output | 1 | A CRC must be appended to this frame |
| busy | output | 1 | A packet is being processed |
| done | output | 1 | Packet processing finished (one cycle) |
| lenErr | output | 1 | Packet dropped for an illegal byte count (one cycle, with `done`) |

## Verification
The bench sweeps stored counts from 0 to 49. It tries both odd-flag values and all four combinations of the CRC flag with the global setting, and it moves the packet to a new base address for each case. Odd stored counts set against their even neighbours separate a design that masks bit 0 from one that does not. The odd flag set against clear, within the same count, shows whether the closing word's low byte is included. Three ready patterns are used: always ready, and two with stalls at different periods. The stalled patterns expose lost or repeated bytes and any output that changes while the byte is not accepted. The boundary counts 4, 5, 6, 1536, 1537, 1538 and 0xFFFF pin down both edges of the legal range, and a `start` pulsed mid-frame at a different base must leave the stream unchanged.

// File: rtl/txu_pkg.sv
package txu_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic ldBase;    // latch base address, clear per-frame state
    logic rdCount;   // read byte-count word
    logic rdCtrl;    // read closing (control) word
    logic rdWord;    // read next data word
    logic capCount;  // capture count word from memory
    logic capCtrl;   // capture closing word, compute length
    logic capWord;   // capture data word, advance pointer
    logic sendByte;  // byte accepted by MAC
    logic selHi;     // present high byte of held word
  } txuStrobes_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CNT_REQ, S_CNT_CAP, S_CTL_REQ, S_CTL_CAP,
    S_WRD_REQ, S_WRD_CAP, S_SEND_LO, S_SEND_HI, S_FIN, S_ERR
  } txuState_t;
endpackage

// File: rtl/txu_datapath.sv
module txu_datapath
  import txu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MAX_COUNT = 1536,
  parameter int MIN_COUNT = 6,
  parameter int ODD_BIT   = 13,
  parameter int CRC_BIT   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  txuStrobes_t       stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              noCrcCfg,
  input  logic [15:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lenBad,
  output logic              zeroLen,
  output logic              lastByte,
  output logic [7:0]        txData,
  output logic              crcAppend
);
  localparam int WORD_W      = 16;
  localparam int OVERHEAD    = 6;
  localparam int MAX_WORDS   = MAX_COUNT / 2;

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] wordPtr;
  logic [WORD_W-1:0] countEff;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] bytesLeft;
  logic              crcBit;

  logic [WORD_W-1:0] countMasked;
  logic [WORD_W-1:0] nextLen;
  logic [ADDR_W-1:0] lastOff;

  assign countMasked = memRdData & ~WORD_W'(1);
  assign lenBad      = (countMasked > WORD_W'(MAX_COUNT)) ||
                       (countMasked < WORD_W'(MIN_COUNT));
  assign nextLen     = countEff - WORD_W'(OVERHEAD) + WORD_W'(memRdData[ODD_BIT]);
  assign zeroLen     = (nextLen == '0);
  assign lastOff     = ADDR_W'(countEff >> 1) - ADDR_W'(1);

  always_comb begin
    memAddr = wordPtr;
    if (stb.rdCount)     memAddr = baseReg + ADDR_W'(1);
    else if (stb.rdCtrl) memAddr = baseReg + lastOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      wordPtr   <= '0;
      countEff  <= '0;
      wordReg   <= '0;
      bytesLeft <= '0;
      crcBit    <= 1'b0;
    end else begin
      if (stb.ldBase) begin
        baseReg <= baseAddr;
        crcBit  <= 1'b0;
      end
      if (stb.capCount) countEff <= countMasked;
      if (stb.capCtrl) begin
        bytesLeft <= nextLen;
        crcBit    <= memRdData[CRC_BIT];
        wordPtr   <= baseReg + ADDR_W'(2);
      end
      if (stb.capWord) begin
        wordReg <= memRdData;
        wordPtr <= wordPtr + ADDR_W'(1);
      end
      if (stb.sendByte) bytesLeft <= bytesLeft - WORD_W'(1);
    end
  end

  assign lastByte  = (bytesLeft == WORD_W'(1));
  assign txData    = stb.selHi ? wordReg[15:8] : wordReg[7:0];
  assign crcAppend = !noCrcCfg || crcBit;

  // R4: never accept a byte beyond the computed length
  assert_send_within_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendByte |-> bytesLeft != '0);
  // R2: data reads stay inside the largest legal packet
  assert_word_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdWord |-> (ADDR_W'(wordPtr - baseReg) < ADDR_W'(MAX_WORDS)));
endmodule

// File: rtl/txu_control.sv
module txu_control
  import txu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        txReady,
  input  logic        lenBad,
  input  logic        zeroLen,
  input  logic        lastByte,
  output txuStrobes_t stb,
  output logic        memRdEn,
  output logic        txValid,
  output logic        busy,
  output logic        done,
  output logic        lenErr
);
  txuState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (start) begin
        stb.ldBase = 1'b1;
        stateNext  = S_CNT_REQ;
      end
      S_CNT_REQ: begin
        stb.rdCount = 1'b1;
        stateNext   = S_CNT_CAP;
      end
      S_CNT_CAP: begin
        stb.capCount = 1'b1;
        stateNext    = lenBad ? S_ERR : S_CTL_REQ;
      end
      S_CTL_REQ: begin
        stb.rdCtrl = 1'b1;
        stateNext  = S_CTL_CAP;
      end
      S_CTL_CAP: begin
        stb.capCtrl = 1'b1;
        stateNext   = zeroLen ? S_FIN : S_WRD_REQ;
      end
      S_WRD_REQ: begin
        stb.rdWord = 1'b1;
        stateNext  = S_WRD_CAP;
      end
      S_WRD_CAP: begin
        stb.capWord = 1'b1;
        stateNext   = S_SEND_LO;
      end
      S_SEND_LO: if (txReady) begin
        stb.sendByte = 1'b1;
        stateNext    = lastByte ? S_FIN : S_SEND_HI;
      end
      S_SEND_HI: begin
        stb.selHi = 1'b1;
        if (txReady) begin
          stb.sendByte = 1'b1;
          stateNext    = lastByte ? S_FIN : S_WRD_REQ;
        end
      end
      S_FIN:   stateNext = S_IDLE;
      S_ERR:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign memRdEn = stb.rdCount || stb.rdCtrl || stb.rdWord;
  assign txValid = (state == S_SEND_LO) || (state == S_SEND_HI);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN) || (state == S_ERR);
  assign lenErr  = (state == S_ERR);

  // R6: an illegal count leads straight to the error strobe
  assert_bad_len_errs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CNT_CAP && lenBad) |=> (lenErr && done && !txValid));
  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3: no memory traffic while a byte is presented
  assert_no_read_in_send_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !memRdEn);
endmodule

// File: rtl/txu_top.sv
module txu_top
  import txu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MAX_COUNT = 1536,
  parameter int MIN_COUNT = 6,
  parameter int ODD_BIT   = 13,
  parameter int CRC_BIT   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              noCrcCfg,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memRdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              crcAppend,
  output logic              busy,
  output logic              done,
  output logic              lenErr
);
  txuStrobes_t stb;
  logic lenBad, zeroLen, lastByte;

  txu_control ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .txReady(txReady),
    .lenBad(lenBad), .zeroLen(zeroLen), .lastByte(lastByte),
    .stb(stb), .memRdEn(memRdEn), .txValid(txValid),
    .busy(busy), .done(done), .lenErr(lenErr)
  );

  txu_datapath #(
    .ADDR_W(ADDR_W), .MAX_COUNT(MAX_COUNT), .MIN_COUNT(MIN_COUNT),
    .ODD_BIT(ODD_BIT), .CRC_BIT(CRC_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .baseAddr(baseAddr),
    .noCrcCfg(noCrcCfg), .memRdData(memRdData), .memAddr(memAddr),
    .lenBad(lenBad), .zeroLen(zeroLen), .lastByte(lastByte),
    .txData(txData), .crcAppend(crcAppend)
  );

  assign txLast = txValid && lastByte;

  // R8: presented byte holds while stalled
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));
  // R5: nothing follows an accepted last byte
  assert_last_ends_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> !txValid);
endmodule

// File: tb/txu_top_tb_top.sv
module txu_top_tb_top;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              noCrcCfg = 1'b0;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0]       memRdData;
  logic              txValid;
  logic              txReady = 1'b0;
  logic [7:0]        txData;
  logic              txLast;
  logic              crcAppend;
  logic              busy;
  logic              done;
  logic              lenErr;

  int errors = 0;
  int checks = 0;

  logic [15:0] mem [0:4095];

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  txu_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .noCrcCfg(noCrcCfg), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txLast(txLast), .crcAppend(crcAppend),
    .busy(busy), .done(done), .lenErr(lenErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expB(input int pid, input int k);
    return 8'((k * 7 + pid * 13 + 1) & 255);
  endfunction

  function automatic bit readyOf(input int mode, input int cyc);
    if (mode == 1) return (cyc % 3) != 1;
    if (mode == 2) return (cyc % 5) < 2;
    return 1'b1;
  endfunction

  task automatic runPkt(input int base, input int cnt, input bit odd, input bit crc,
                        input bit ncrc, input int rmode, input bit mid, input int pid);
    int eff = cnt & 32'hFFFE;
    bit bad = (eff > 1536) || (eff < 6);
    int n   = bad ? 0 : eff - 6 + int'(odd);
    int lastW = eff / 2 - 1;
    int idx = 0;
    int doneCnt = 0;
    int sinceDone = 0;
    bit errSeen = 1'b0;
    bit dataOk = 1'b1;
    bit lastOk = 1'b1;
    bit stallOk = 1'b1;
    bit anyValid = 1'b0;
    bit prevStall = 1'b0;
    logic [7:0] prevData = '0;
    logic prevLast = 1'b0;
    mem[base] = 16'hA5A5 ^ 16'(pid);
    mem[(base + 1) % 4096] = 16'(cnt);
    if (!bad) begin
      for (int j = 2; j < lastW; j++)
        mem[(base + j) % 4096] = {expB(pid, 2*(j-2)+1), expB(pid, 2*(j-2))};
      mem[(base + lastW) % 4096] = {8'h8A | (8'(odd) << 5) | (8'(crc) << 4),
                                    odd ? expB(pid, 2*(lastW-2)) : 8'hEE};
    end
    @(negedge clk);
    noCrcCfg = ncrc;
    baseAddr = ADDR_W'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      txReady = readyOf(rmode, cyc);
      if (mid && cyc == 6) begin
        start = 1'b1;
        baseAddr = ADDR_W'((base + 777) % 4096);
      end else start = 1'b0;
      if (done) doneCnt++;
      if (lenErr) errSeen = 1'b1;
      if (txValid) begin
        anyValid = 1'b1;
        if (prevStall && (txData != prevData || txLast != prevLast)) stallOk = 1'b0;
        if (txReady) begin
          if (idx >= n || txData != expB(pid, idx)) dataOk = 1'b0;
          if (txLast != (idx == n - 1)) lastOk = 1'b0;
          idx++;
        end
        prevStall = !txReady;
        prevData = txData;
        prevLast = txLast;
      end else prevStall = 1'b0;
      if (doneCnt > 0) sinceDone++;
      if (sinceDone >= 3) break;
      @(negedge clk);
    end
    start = 1'b0;
    check(doneCnt == 1, "R10 done single pulse", doneCnt, 1);
    if (bad) begin
      check(errSeen && !anyValid, "R6 bad count dropped", int'(anyValid), 0);
    end else begin
      check(!errSeen, "R6 no error on legal count", int'(errSeen), 0);
      check(idx == n, "R2/R4 byte count", idx, n);
      check(dataOk, "R3 data bytes", int'(dataOk), 1);
      check(lastOk, "R5 last flag", int'(lastOk), 1);
      check(crcAppend == (!ncrc || crc), "R7 crc request", int'(crcAppend), int'(!ncrc || crc));
      if (rmode != 0) check(stallOk, "R8 hold while stalled", int'(stallOk), 1);
      if (n == 0) check(!anyValid, "R9 zero-length frame", int'(anyValid), 0);
    end
  endtask

  initial begin
    int pid = 0;
    repeat (3) @(negedge clk);
    check(!txValid && !memRdEn && !busy && !done && !lenErr, "R1 reset state",
          int'({txValid, memRdEn, busy, done, lenErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!txValid && !busy, "R1 idle after reset", int'({txValid, busy}), 0);
    for (int cnt = 0; cnt < 50; cnt++)
      for (int odd = 0; odd < 2; odd++)
        for (int cfg = 0; cfg < 4; cfg++) begin
          runPkt((pid * 53) % 2048, cnt, odd[0], cfg[0], cfg[1], (cnt + cfg) % 3, 1'b0, pid);
          pid++;
        end
    runPkt(100, 1536, 1'b1, 1'b1, 1'b1, 0, 1'b0, pid++);
    runPkt(900, 1537, 1'b1, 1'b0, 1'b1, 1, 1'b0, pid++);
    runPkt(1700, 1536, 1'b0, 1'b0, 1'b0, 2, 1'b0, pid++);
    runPkt(10, 1538, 1'b0, 1'b0, 1'b0, 0, 1'b0, pid++);
    runPkt(20, 16'hFFFF, 1'b1, 1'b0, 1'b0, 0, 1'b0, pid++);
    runPkt(30, 5, 1'b1, 1'b0, 1'b0, 0, 1'b0, pid++);
    runPkt(40, 7, 1'b0, 1'b1, 1'b1, 0, 1'b0, pid++);
    runPkt(300, 40, 1'b1, 1'b1, 1'b1, 1, 1'b1, pid++);
    runPkt(600, 41, 1'b0, 1'b0, 1'b1, 0, 1'b1, pid++);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule